// File: doc/BRIEF.md
# Two-Level Non-Maskable Interrupt Arbiter

This block decides which interrupt a small processor core takes next. It serves three classes of request. System-level non-maskable requests rank highest. User-level non-maskable requests come next. A bank of maskable peripheral requests ranks lowest. Each non-maskable source is an edge-type line. The block detects the rising edge and keeps it in a pending flag. Each maskable source is a level-type line and is used as it stands. Every source has its own enable bit. A global enable gates the maskable class only.

When a request wins, the block raises a take request with a vector index and holds both until the core acknowledges. An acknowledged non-maskable request marks its level as in service, and the level stays blocked until the matching return strobe. Returning from a system-level handler opens a gap. No take request is made until the core reports one retired main-program instruction. Under a continuous storm of system-level requests, the main program therefore still makes progress, and user-level requests keep waiting until the storm ends.

Top module: `nmi_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, `take` is 0, `vec` is 0, and both in-service outputs are 0.
- R2: A rising edge on a system or user request line sets that source's pending flag. A line held high sets it only once. The vector index numbers the system sources 0..N_SYS-1, the user sources N_SYS..N_SYS+N_USR-1, and maskable source k as N_SYS+N_USR+k.
- R3: A non-maskable source whose enable bit is 0 is never taken. Its pending flag is kept, and the source is taken once the enable is set.
- R4: Non-maskable sources are taken whatever the value of `gie`. A maskable source is taken only when both its enable bit and `gie` are 1.
- R5: When several requests compete, system wins over user, and user wins over maskable. Within a class, the lowest index wins.
- R6: Once `take` is raised, `take` and `vec` stay unchanged until `ack`. The cycle after `ack`, `take` is 0. The accepted non-maskable level shows in service, and the accepted source's pending flag is cleared.
- R7: While system is in service, nothing is taken. While only user is in service, only system sources can be taken.
- R8: A `reti` pulse clears system in-service if it is set, and otherwise clears user in-service. Software never needs to re-enable sources.
- R9: After a `reti` that ends a system handler, no take is raised until `instr_ret` has pulsed. A system request pending at that time is then taken ahead of a pending user request.
- R10: Maskable requests are not latched. A maskable line that drops before it could be taken causes no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_req | input | N_SYS | System-level edge request lines |
| sys_en | input | N_SYS | Per-source enables, system level |
| usr_req | input | N_USR | User-level edge request lines |
| usr_en | input | N_USR | Per-source enables, user level |
| msk_req | input | N_MSK | Maskable level request lines |
| msk_en | input | N_MSK | Per-source enables, maskable |
| gie | input | 1 | Global enable for maskable requests |
| ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Core executed a return from interrupt |
| instr_ret | input | 1 | One main-program instruction retired |
| take | output | 1 | Interrupt-take request to the core |
| vec | output | IDX_W | Index of the winning source |
| sys_busy | output | 1 | System level in service |
| usr_busy | output | 1 | User level in service |

## Verification
An edge on a non-maskable line sets its pending flag at the next clock. `take` follows one clock after that. A maskable level present with its enables appears on `take` one clock after it is sampled. `ack`, `reti` and `instr_ret` each change the in-service and gap state at the edge that samples them. The bench drives inputs on the falling edge. A behavioural model steps at each rising edge, using the same one-edge-per-register timing, and the outputs are compared with the model on every falling edge. Directed checks wait a fixed number of falling edges or poll for `take` with a limit, so every sample falls after the edge on which the value is due.

// File: rtl/nmi_arb_pkg.sv
package nmi_arb_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SYS  = 2'd1,
    WIN_USR  = 2'd2,
    WIN_MSK  = 2'd3
  } win_e;
endpackage

// File: rtl/nmi_edge_pend.sv
module nmi_edge_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        prev[g] <= 1'b0;
        pend[g] <= 1'b0;
      end else begin
        prev[g] <= req[g];
        // a fresh edge wins over a clear in the same cycle
        pend[g] <= (pend[g] & ~clr[g]) | (req[g] & ~prev[g]);
      end
    end
  end
endmodule

// File: rtl/nmi_low_pick.sv
module nmi_low_pick #(
  parameter int N  = 4,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/nmi_svc_state.sv
module nmi_svc_state (
  input  logic clk,
  input  logic rst,
  input  logic acc_sys,
  input  logic acc_usr,
  input  logic reti,
  input  logic instr_ret,
  output logic sys_busy,
  output logic usr_busy,
  output logic gap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sys_busy <= 1'b0;
      usr_busy <= 1'b0;
      gap      <= 1'b0;
    end else begin
      if (reti && sys_busy) begin
        sys_busy <= 1'b0;
        gap      <= 1'b1;
      end else begin
        if (reti && usr_busy) usr_busy <= 1'b0;
        if (instr_ret) gap <= 1'b0;
      end
      if (acc_sys) sys_busy <= 1'b1;
      if (acc_usr) usr_busy <= 1'b1;
    end
  end
endmodule

// File: rtl/nmi_arbiter.sv
module nmi_arbiter
  import nmi_arb_pkg::*;
#(
  parameter int N_SYS = 3,
  parameter int N_USR = 2,
  parameter int N_MSK = 8,
  localparam int N_ALL = N_SYS + N_USR + N_MSK,
  localparam int IDX_W = $clog2(N_ALL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SYS-1:0] sys_req,
  input  logic [N_SYS-1:0] sys_en,
  input  logic [N_USR-1:0] usr_req,
  input  logic [N_USR-1:0] usr_en,
  input  logic [N_MSK-1:0] msk_req,
  input  logic [N_MSK-1:0] msk_en,
  input  logic             gie,
  input  logic             ack,
  input  logic             reti,
  input  logic             instr_ret,
  output logic             take,
  output logic [IDX_W-1:0] vec,
  output logic             sys_busy,
  output logic             usr_busy
);
  localparam logic [IDX_W-1:0] USR_BASE = IDX_W'(N_SYS);
  localparam logic [IDX_W-1:0] MSK_BASE = IDX_W'(N_SYS + N_USR);

  logic [N_SYS-1:0] sys_pend, sys_clr;
  logic [N_USR-1:0] usr_pend, usr_clr;
  logic             sys_hit, usr_hit, msk_hit;
  logic [IDX_W-1:0] sys_idx, usr_idx, msk_idx, win_idx;
  logic             gap, accept, acc_sys, acc_usr, fire;
  logic             take_q;
  logic [IDX_W-1:0] vec_q;
  win_e             win;

  assign accept  = take_q & ack;
  assign acc_sys = accept & (vec_q < USR_BASE);
  assign acc_usr = accept & (vec_q >= USR_BASE) & (vec_q < MSK_BASE);

  for (genvar s = 0; s < N_SYS; s++) begin : g_sclr
    assign sys_clr[s] = accept & (vec_q == IDX_W'(s));
  end
  for (genvar u = 0; u < N_USR; u++) begin : g_uclr
    assign usr_clr[u] = accept & (vec_q == IDX_W'(N_SYS + u));
  end

  nmi_edge_pend #(.N(N_SYS)) u_sys_pend (
    .clk(clk), .rst(rst), .req(sys_req), .clr(sys_clr), .pend(sys_pend)
  );
  nmi_edge_pend #(.N(N_USR)) u_usr_pend (
    .clk(clk), .rst(rst), .req(usr_req), .clr(usr_clr), .pend(usr_pend)
  );

  nmi_low_pick #(.N(N_SYS), .IW(IDX_W)) u_sys_pick (
    .req(sys_pend & sys_en), .hit(sys_hit), .idx(sys_idx)
  );
  nmi_low_pick #(.N(N_USR), .IW(IDX_W)) u_usr_pick (
    .req(usr_pend & usr_en), .hit(usr_hit), .idx(usr_idx)
  );
  nmi_low_pick #(.N(N_MSK), .IW(IDX_W)) u_msk_pick (
    .req(msk_req & msk_en), .hit(msk_hit), .idx(msk_idx)
  );

  nmi_svc_state u_state (
    .clk(clk), .rst(rst), .acc_sys(acc_sys), .acc_usr(acc_usr),
    .reti(reti), .instr_ret(instr_ret),
    .sys_busy(sys_busy), .usr_busy(usr_busy), .gap(gap)
  );

  always_comb begin
    win = WIN_NONE;
    if (!sys_busy) begin
      if (sys_hit)                    win = WIN_SYS;
      else if (!usr_busy && usr_hit)  win = WIN_USR;
      else if (!usr_busy && gie && msk_hit) win = WIN_MSK;
    end
    case (win)
      WIN_SYS: win_idx = sys_idx;
      WIN_USR: win_idx = USR_BASE + usr_idx;
      WIN_MSK: win_idx = MSK_BASE + msk_idx;
      default: win_idx = '0;
    endcase
    fire = !take_q && !gap && (win != WIN_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else if (accept) begin
      take_q <= 1'b0;
    end else if (fire) begin
      take_q <= 1'b1;
      vec_q  <= win_idx;
    end
  end

  assign take = take_q;
  assign vec  = vec_q;
endmodule

// File: rtl/nmi_arbiter_chk.sv
module nmi_arbiter_chk #(
  parameter int N_SYS = 3,
  parameter int N_USR = 2,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             gie,
  input logic             ack,
  input logic             reti,
  input logic             instr_ret,
  input logic             take,
  input logic [IDX_W-1:0] vec,
  input logic             sys_busy,
  input logic             usr_busy
);
  logic gap_seen;
  always_ff @(posedge clk) begin
    if (rst) gap_seen <= 1'b0;
    else if (reti && sys_busy) gap_seen <= 1'b1;
    else if (instr_ret) gap_seen <= 1'b0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!take && !sys_busy && !usr_busy));

  a_r6_hold_vec: assert property (@(posedge clk) disable iff (rst)
    (take && !ack) |=> (take && $stable(vec)));

  a_r6_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    (take && ack) |=> !take);

  a_r7_sys_blocks_all: assert property (@(posedge clk) disable iff (rst)
    $rose(take) |-> !$past(sys_busy));

  a_r7_usr_blocks_low: assert property (@(posedge clk) disable iff (rst)
    ($rose(take) && $past(usr_busy)) |-> (vec < IDX_W'(N_SYS)));

  a_r4_gie_gates_msk: assert property (@(posedge clk) disable iff (rst)
    ($rose(take) && vec >= IDX_W'(N_SYS + N_USR)) |-> $past(gie));

  a_r9_gap_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(take) |-> !$past(gap_seen));
endmodule

bind nmi_arbiter nmi_arbiter_chk #(
  .N_SYS(N_SYS), .N_USR(N_USR), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .ack(ack), .reti(reti),
  .instr_ret(instr_ret), .take(take), .vec(vec),
  .sys_busy(sys_busy), .usr_busy(usr_busy)
);

// File: tb/sim_nmi_arbiter.sv
`timescale 1ns/1ps
module sim_nmi_arbiter;
  localparam int NS = 3, NU = 2, NM = 8;
  localparam int IW = $clog2(NS + NU + NM);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] sys_req = '0, sys_en = '0;
  logic [NU-1:0] usr_req = '0, usr_en = '0;
  logic [NM-1:0] msk_req = '0, msk_en = '0;
  logic gie = 1'b0, ack = 1'b0, reti = 1'b0, instr_ret = 1'b0;
  logic take, sys_busy, usr_busy;
  logic [IW-1:0] vec;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  nmi_arbiter #(.N_SYS(NS), .N_USR(NU), .N_MSK(NM)) u0 (
    .clk(clk), .rst(rst), .sys_req(sys_req), .sys_en(sys_en),
    .usr_req(usr_req), .usr_en(usr_en), .msk_req(msk_req), .msk_en(msk_en),
    .gie(gie), .ack(ack), .reti(reti), .instr_ret(instr_ret),
    .take(take), .vec(vec), .sys_busy(sys_busy), .usr_busy(usr_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_take, m_sb, m_ub, m_gap;
  int m_vec;
  bit sp[NS], sprev[NS], up[NU], uprev[NU];

  always @(posedge clk) begin
    bit nt, nsb, nub, ngap;
    int nv, w;
    if (rst) begin
      m_take = 0; m_vec = 0; m_sb = 0; m_ub = 0; m_gap = 0;
      foreach (sp[i]) begin sp[i] = 0; sprev[i] = 0; end
      foreach (up[i]) begin up[i] = 0; uprev[i] = 0; end
    end else begin
      nt = m_take; nv = m_vec; nsb = m_sb; nub = m_ub; ngap = m_gap;
      if (reti && m_sb) begin nsb = 0; ngap = 1; end
      else begin
        if (reti && m_ub) nub = 0;
        if (instr_ret) ngap = 0;
      end
      if (m_take && ack) begin
        nt = 0;
        if (m_vec < NS) begin nsb = 1; sp[m_vec] = 0; end
        else if (m_vec < NS + NU) begin nub = 1; up[m_vec - NS] = 0; end
      end else if (!m_take && !m_gap && !m_sb) begin
        w = -1;
        for (int i = 0; i < NS; i++) if (w < 0 && sp[i] && sys_en[i]) w = i;
        if (w < 0 && !m_ub)
          for (int i = 0; i < NU; i++) if (w < 0 && up[i] && usr_en[i]) w = NS + i;
        if (w < 0 && !m_ub && gie)
          for (int i = 0; i < NM; i++) if (w < 0 && msk_req[i] && msk_en[i]) w = NS + NU + i;
        if (w >= 0) begin nt = 1; nv = w; end
      end
      for (int i = 0; i < NS; i++) begin
        if (sys_req[i] && !sprev[i]) sp[i] = 1;
        sprev[i] = sys_req[i];
      end
      for (int i = 0; i < NU; i++) begin
        if (usr_req[i] && !uprev[i]) up[i] = 1;
        uprev[i] = usr_req[i];
      end
      m_take = nt; m_vec = nv; m_sb = nsb; m_ub = nub; m_gap = ngap;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(take == m_take, "R5 model take", int'(take), int'(m_take));
      chk(int'(vec) == m_vec, "R5 model vec", int'(vec), m_vec);
      chk(sys_busy == m_sb, "R6 model sys_busy", int'(sys_busy), int'(m_sb));
      chk(usr_busy == m_ub, "R8 model usr_busy", int'(usr_busy), int'(m_ub));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(take == 1'b0, tag, int'(take), 0);
    end
  endtask

  task automatic serve(input int exp, input int hold, input string tag);
    int t;
    int v0;
    t = 0;
    while (!take && t < 20) begin @(negedge clk); t++; end
    chk(take == 1'b1, tag, int'(take), 1);
    chk(int'(vec) == exp, tag, int'(vec), exp);
    v0 = int'(vec);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(take && int'(vec) == v0, "R6 hold until ack", int'(vec), v0);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  task automatic pulse_ret();
    instr_ret = 1'b1; @(negedge clk); instr_ret = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    tick(3);
    chk(take == 0 && vec == 0 && !sys_busy && !usr_busy, "R1 in reset", int'(take), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(take == 0 && !sys_busy && !usr_busy, "R1 after reset", int'(take), 0);
    sys_en = '1; usr_en = '1; msk_en = '1; gie = 1'b0;

    // R2: edge on system line 1, vector 1
    sys_req[1] = 1'b1; tick(3); sys_req[1] = 1'b0;
    serve(1, 2, "R2 system edge taken");
    chk(sys_busy == 1'b1, "R6 system in service", int'(sys_busy), 1);
    // R7: nothing while system in service
    sys_req[2] = 1'b1; usr_req[0] = 1'b1; msk_req[0] = 1'b1; gie = 1'b1;
    @(negedge clk); sys_req[2] = 1'b0; usr_req[0] = 1'b0;
    quiet(5, "R7 system busy blocks all");
    msk_req[0] = 1'b0; gie = 1'b0;
    // R8 / R9: return opens gap
    pulse_reti();
    chk(sys_busy == 1'b0, "R8 reti clears system", int'(sys_busy), 0);
    quiet(4, "R9 gap holds take");
    pulse_ret();
    serve(2, 0, "R9 storm re-entry before user");
    pulse_reti(); quiet(2, "R9 gap after second exit"); pulse_ret();
    serve(NS + 0, 0, "R5 user after system storm");
    chk(usr_busy == 1'b1, "R6 user in service", int'(usr_busy), 1);
    // R7: system preempts user handler; user and maskable blocked
    usr_req[1] = 1'b1; msk_req[4] = 1'b1; gie = 1'b1;
    @(negedge clk); usr_req[1] = 1'b0;
    quiet(4, "R7 user busy blocks user and maskable");
    sys_req[0] = 1'b1; @(negedge clk); sys_req[0] = 1'b0;
    serve(0, 0, "R7 system preempts user");
    pulse_reti();
    chk(!sys_busy && usr_busy, "R8 reti clears system first", int'(usr_busy), 1);
    pulse_ret();
    pulse_reti();
    chk(usr_busy == 1'b0, "R8 reti clears user", int'(usr_busy), 0);
    serve(NS + 1, 0, "R5 pending user next");
    msk_req[4] = 1'b0;
    pulse_reti();

    // R4: maskable needs gie
    gie = 1'b0; msk_req[5] = 1'b1;
    quiet(4, "R4 gie low blocks maskable");
    gie = 1'b1;
    serve(NS + NU + 5, 1, "R4 maskable with gie");
    msk_req[5] = 1'b0;
    tick(2);
    // R10: level source not latched
    gie = 1'b0; msk_req[3] = 1'b1; tick(2); msk_req[3] = 1'b0; gie = 1'b1;
    quiet(4, "R10 dropped maskable not taken");
    // R5: lowest maskable index
    msk_req[6] = 1'b1; msk_req[2] = 1'b1; msk_en[6] = 1'b1;
    ack = 1'b0;
    serve(NS + NU + 2, 0, "R5 lowest maskable wins");
    msk_req = '0;
    tick(2);
    // R3: disabled system source kept pending
    sys_en[0] = 1'b0; sys_req[0] = 1'b1; @(negedge clk); sys_req[0] = 1'b0;
    quiet(4, "R3 disabled source not taken");
    sys_en[0] = 1'b1;
    serve(0, 0, "R3 enabled source taken from pending");
    pulse_reti(); pulse_ret();
    // R4: NMI ignores gie
    gie = 1'b0; usr_req[1] = 1'b1; @(negedge clk); usr_req[1] = 1'b0;
    serve(NS + 1, 0, "R4 user taken with gie low");
    pulse_reti();
    // R2: held-high line latches once
    sys_req[1] = 1'b1;
    serve(1, 0, "R2 held line first take");
    pulse_reti(); pulse_ret();
    quiet(5, "R2 held line no second take");
    sys_req[1] = 1'b0;
    tick(3);
    finish_run();
  end
endmodule